// File: doc/BRIEF.md
# Vector Element Address Generator

This block turns one vector memory instruction into a stream of element byte addresses for the memory banks behind it. Software-visible state is not kept here. A caller gives a start pulse along with the following configuration: a base address, an element width code, a vector length, an access mode and an element stride. The block then walks the vector four elements at a time. In unit-stride and strided modes it computes each address from the element index. In indexed mode it adds one byte offset per element, taken from a separate offset stream, to the base.

Every output beat carries four lanes. Each lane has an address, the bank that the address falls in, a valid bit and an element count. When the element stride is small (one to four elements, and always in unit-stride mode), neighbouring elements often land in the same 32-byte memory row. The block then folds those elements into the request of the first lane that opened the row, so that each row is asked for once per beat. A short queue sits between the generator and the output handshake. It lets the address stream run ahead of a consumer that is still waiting for store data. A one-cycle completion pulse follows acceptance of the final beat.

Top module: `vec_agen`

## Requirements
- R1: In unit-stride mode (mode code 0) and strided mode (code 1, and also code 3), element e gets address base + e*S*B modulo 2^32. S is `cfg_stride` in strided mode and 1 in unit-stride mode. B is the element size in bytes: width code 0 gives 2, code 1 gives 4, and codes 2 and 3 give 8.
- R2: In indexed mode (code 2), element e gets address base + offset(e), where offset(e) is the zero-extended 16-bit byte offset. One offset beat is consumed per output beat, and lane j takes its offset from `idx_off[16*j +: 16]`.
- R3: Beat b holds elements 4b to 4b+3 in lanes 0 to 3. A beat is produced for every element group below the vector length. Lanes at or past the vector length are invalid, and lane 0 of every beat is valid.
- R4: The bank of every valid lane equals bits [7:5] of that lane's address.
- R5: In unit-stride mode, and in strided mode with a stride of 1 to 4, a lane is dropped from the beat when its address lies in the same 32-byte row (address bits [31:5]) as the lane below it. The surviving lane that opened the row reports in `out_cnt` how many elements of the beat fall in its row. With any other stride, and in indexed mode, each element lane is valid with a count of 1.
- R6: A beat offered with `out_valid` stays unchanged until `out_ready` accepts it. No beat is lost or repeated under any pattern of `out_ready`. Up to four beats can queue ahead of the consumer.
- R7: `out_last` marks the final beat of a vector. `done` is high for exactly one cycle, the cycle after that beat is accepted.
- R8: A start with vector length 0 raises `done` in the next cycle and produces no beat.
- R9: A start pulse, together with any change of the configuration inputs, is ignored while `busy` is high.
- R10: `idx_ready` is never high during a unit-stride or strided run.
- R11: After reset, `out_valid`, `done`, `busy` and `idx_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a vector when idle |
| cfg_mode | input | 2 | 0 unit-stride, 1 strided, 2 indexed, 3 strided |
| cfg_width | input | 2 | Element size: 0 16-bit, 1 32-bit, 2/3 64-bit |
| cfg_vlen | input | VLW (8) | Number of elements |
| cfg_base | input | AW (32) | Base byte address |
| cfg_stride | input | STRW (8) | Element stride in elements (strided mode) |
| idx_valid | input | 1 | Offset beat present |
| idx_ready | output | 1 | Offset beat taken at this edge |
| idx_off | input | LANES*OFFW (64) | Four byte offsets, lane j at [16j +: 16] |
| out_valid | output | 1 | Address beat present |
| out_ready | input | 1 | Consumer takes the beat |
| out_addr | output | LANES*AW (128) | Lane addresses, lane j at [32j +: 32] |
| out_bank | output | LANES*3 (12) | Lane bank numbers |
| out_lane_vld | output | LANES (4) | Lane valid bits |
| out_cnt | output | LANES*3 (12) | Elements covered by each lane |
| out_last | output | 1 | Final beat of the vector |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Generating, or beats still queued |

## Verification
The assertions assume a consumer that may stall at will, and an offset stream that is only meaningful while the block asks for it. Beyond that, they make no assumption about `start` arriving while busy or about `out_ready` patterns. The bench keeps each new start until `busy` is low and `done` has been seen. The exception is a run that deliberately pulses `start` mid-vector with a different configuration. The offset feeder holds a beat steady until `idx_ready` accepts it. Strides, bases and lengths are chosen so that rows are crossed at every lane position and partial final beats occur, with `out_ready` held high, toggled, or random.

// File: rtl/vec_agen_pkg.sv
package vec_agen_pkg;

  localparam int ROW_BITS  = 5;
  localparam int BANK_BITS = 3;

  typedef enum logic [1:0] {
    MODE_UNIT   = 2'd0,
    MODE_STRIDE = 2'd1,
    MODE_INDEX  = 2'd2,
    MODE_ALT    = 2'd3
  } agen_mode_e;

  function automatic logic [3:0] elem_bytes(input logic [1:0] wcode);
    case (wcode)
      2'd0:    return 4'd2;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [BANK_BITS-1:0] bank_of(input logic [ROW_BITS+BANK_BITS-1:0] low);
    return low[ROW_BITS +: BANK_BITS];
  endfunction

  function automatic logic stride_is_fast(input logic [7:0] s);
    return (s >= 8'd1) && (s <= 8'd4);
  endfunction

endpackage

// File: rtl/agen_lane.sv
module agen_lane
  import vec_agen_pkg::*;
#(
  parameter int AW   = 32,
  parameter int EW   = 10,
  parameter int STRW = 8,
  parameter int OFFW = 16
) (
  input  logic [AW-1:0]        base,
  input  logic [EW-1:0]        elem,
  input  logic [STRW-1:0]      stride,
  input  logic [1:0]           wcode,
  input  logic                 use_off,
  input  logic [OFFW-1:0]      off,
  output logic [AW-1:0]        addr,
  output logic [BANK_BITS-1:0] bank
);
  localparam int PW = EW + STRW + 4;

  logic [PW-1:0] span;

  always_comb begin
    span = PW'(elem) * PW'(stride) * PW'(elem_bytes(wcode));
    if (use_off) addr = base + AW'(off);
    else         addr = base + AW'(span);
    bank = bank_of(addr[ROW_BITS+BANK_BITS-1:0]);
  end
endmodule

// File: rtl/agen_merge.sv
module agen_merge
  import vec_agen_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LANES = 4,
  parameter int CW    = 3
) (
  input  logic [LANES-1:0][AW-1:0] addr,
  input  logic [LANES-1:0]         raw_v,
  input  logic                     fast,
  output logic [LANES-1:0]         lead_v,
  output logic [LANES-1:0][CW-1:0] cnt
);
  logic [LANES-1:0] folds;
  logic [CW-1:0]    run;

  always_comb begin
    folds = '0;
    for (int j = 1; j < LANES; j++)
      folds[j] = fast && raw_v[j] &&
                 (addr[j][AW-1:ROW_BITS] == addr[j-1][AW-1:ROW_BITS]);
    lead_v = raw_v & ~folds;
    run = '0;
    for (int j = LANES - 1; j >= 0; j--) begin
      if (raw_v[j]) run = run + CW'(1);
      if (lead_v[j]) begin
        cnt[j] = run;
        run    = '0;
      end else begin
        cnt[j] = '0;
      end
    end
  end
endmodule

// File: rtl/agen_fifo.sv
module agen_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         full,
  output logic         empty
);
  localparam int PTRW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNTW = $clog2(DEPTH + 1);

  logic [W-1:0]    mem [DEPTH];
  logic [PTRW-1:0] wp, rp;
  logic [CNTW-1:0] fill;

  assign full  = (fill == CNTW'(DEPTH));
  assign empty = (fill == '0);
  assign dout  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; fill <= '0;
    end else begin
      if (push) wp <= (wp == PTRW'(DEPTH-1)) ? '0 : wp + PTRW'(1);
      if (pop)  rp <= (rp == PTRW'(DEPTH-1)) ? '0 : rp + PTRW'(1);
      if (push && !pop)      fill <= fill + CNTW'(1);
      else if (pop && !push) fill <= fill - CNTW'(1);
    end
  end
endmodule

// File: rtl/vec_agen.sv
module vec_agen
  import vec_agen_pkg::*;
#(
  parameter int AW     = 32,
  parameter int LANES  = 4,
  parameter int VLW    = 8,
  parameter int STRW   = 8,
  parameter int OFFW   = 16,
  parameter int QDEPTH = 4
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start,
  input  logic [1:0]                 cfg_mode,
  input  logic [1:0]                 cfg_width,
  input  logic [VLW-1:0]             cfg_vlen,
  input  logic [AW-1:0]              cfg_base,
  input  logic [STRW-1:0]            cfg_stride,
  input  logic                       idx_valid,
  output logic                       idx_ready,
  input  logic [LANES*OFFW-1:0]      idx_off,
  output logic                       out_valid,
  input  logic                       out_ready,
  output logic [LANES*AW-1:0]        out_addr,
  output logic [LANES*BANK_BITS-1:0] out_bank,
  output logic [LANES-1:0]           out_lane_vld,
  output logic [LANES*3-1:0]         out_cnt,
  output logic                       out_last,
  output logic                       done,
  output logic                       busy
);
  localparam int EW   = VLW + 2;
  localparam int CW   = 3;
  localparam int ENTW = LANES * (AW + BANK_BITS + 1 + CW) + 1;

  agen_mode_e     mode_r;
  logic [1:0]     wcode_r;
  logic [VLW-1:0] vlen_r;
  logic [AW-1:0]  base_r;
  logic [STRW-1:0] stride_r;
  logic [EW-1:0]  elem_idx;
  logic           busy_gen;

  logic [EW-1:0]  remaining;
  logic           is_idx, fast, fifo_full, fifo_empty;
  logic           start_ok, zero_start, gen_fire, gen_last, pop, pop_last;
  logic [STRW-1:0] stride_eff;

  logic [LANES-1:0][AW-1:0]        lane_addr;
  logic [LANES-1:0][BANK_BITS-1:0] lane_bank;
  logic [LANES-1:0]                raw_v, lead_v;
  logic [LANES-1:0][CW-1:0]        lane_cnt;
  logic [ENTW-1:0]                 ent_in, ent_out;

  logic [LANES-1:0][AW-1:0]        q_addr;
  logic [LANES-1:0][BANK_BITS-1:0] q_bank;
  logic [LANES-1:0]                q_v;
  logic [LANES-1:0][CW-1:0]        q_cnt;
  logic                            q_last;

  assign is_idx     = (mode_r == MODE_INDEX);
  assign stride_eff = (mode_r == MODE_UNIT) ? STRW'(1) : stride_r;
  assign fast       = (mode_r == MODE_UNIT) ||
                      (!is_idx && stride_is_fast(8'(stride_r)));
  assign remaining  = EW'(vlen_r) - elem_idx;
  assign gen_last   = (remaining <= EW'(LANES));
  assign gen_fire   = busy_gen && !fifo_full && (!is_idx || idx_valid);
  assign idx_ready  = busy_gen && is_idx && !fifo_full;
  assign start_ok   = start && !busy_gen && fifo_empty;
  assign zero_start = start_ok && (cfg_vlen == '0);

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign raw_v[j] = (EW'(j) < remaining);
    agen_lane #(.AW(AW), .EW(EW), .STRW(STRW), .OFFW(OFFW)) u_lane (
      .base   (base_r),
      .elem   (elem_idx + EW'(j)),
      .stride (stride_eff),
      .wcode  (wcode_r),
      .use_off(is_idx),
      .off    (idx_off[j*OFFW +: OFFW]),
      .addr   (lane_addr[j]),
      .bank   (lane_bank[j])
    );
  end

  agen_merge #(.AW(AW), .LANES(LANES), .CW(CW)) u_merge (
    .addr  (lane_addr),
    .raw_v (raw_v),
    .fast  (fast),
    .lead_v(lead_v),
    .cnt   (lane_cnt)
  );

  assign ent_in = {gen_last, lane_cnt, lead_v, lane_bank, lane_addr};

  agen_fifo #(.W(ENTW), .DEPTH(QDEPTH)) u_queue (
    .clk  (clk),
    .rst_n(rst_n),
    .push (gen_fire),
    .din  (ent_in),
    .pop  (pop),
    .dout (ent_out),
    .full (fifo_full),
    .empty(fifo_empty)
  );

  assign {q_last, q_cnt, q_v, q_bank, q_addr} = ent_out;
  assign out_valid    = !fifo_empty;
  assign pop          = out_valid && out_ready;
  assign pop_last     = pop && q_last;
  assign out_addr     = q_addr;
  assign out_bank     = q_bank;
  assign out_lane_vld = q_v;
  assign out_cnt      = q_cnt;
  assign out_last     = q_last;
  assign busy         = busy_gen || !fifo_empty;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_r   <= MODE_UNIT;
      wcode_r  <= '0;
      vlen_r   <= '0;
      base_r   <= '0;
      stride_r <= '0;
      elem_idx <= '0;
      busy_gen <= 1'b0;
      done     <= 1'b0;
    end else begin
      if (start_ok) begin
        mode_r   <= agen_mode_e'(cfg_mode);
        wcode_r  <= cfg_width;
        vlen_r   <= cfg_vlen;
        base_r   <= cfg_base;
        stride_r <= cfg_stride;
        elem_idx <= '0;
        busy_gen <= (cfg_vlen != '0);
      end else if (gen_fire) begin
        elem_idx <= elem_idx + EW'(LANES);
        if (gen_last) busy_gen <= 1'b0;
      end
      done <= pop_last || zero_start;
    end
  end
endmodule

// File: rtl/vec_agen_chk.sv
module vec_agen_chk (
  input logic clk,
  input logic rst_n,
  input logic out_valid,
  input logic out_ready,
  input logic [127:0] out_addr,
  input logic [3:0] out_lane_vld,
  input logic [2:0] lane0_cnt,
  input logic done,
  input logic idx_ready,
  input logic is_idx,
  input logic busy_gen,
  input logic gen_fire,
  input logic gen_last,
  input logic pop_last,
  input logic zero_start
);
  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_addr) && $stable(out_lane_vld));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R7
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(pop_last || zero_start));

  // R10
  idx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx_ready |-> is_idx && busy_gen);

  // R3
  lane_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_lane_vld[0]);

  // R5
  lead_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> lane0_cnt != 3'd0);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_gen) |-> $past(gen_fire && gen_last));
endmodule

bind vec_agen vec_agen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .out_valid   (out_valid),
  .out_ready   (out_ready),
  .out_addr    (out_addr),
  .out_lane_vld(out_lane_vld),
  .lane0_cnt   (out_cnt[2:0]),
  .done        (done),
  .idx_ready   (idx_ready),
  .is_idx      (is_idx),
  .busy_gen    (busy_gen),
  .gen_fire    (gen_fire),
  .gen_last    (gen_last),
  .pop_last    (pop_last),
  .zero_start  (zero_start)
);

// File: tb/vec_agen_bench.sv
module vec_agen_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_width = '0;
  logic [7:0] cfg_vlen = '0, cfg_stride = '0;
  logic [31:0] cfg_base = '0;
  logic idx_valid = 1'b0;
  logic idx_ready;
  logic [63:0] idx_off = '0;
  logic out_valid, out_last, done, busy;
  logic out_ready = 1'b0;
  logic [127:0] out_addr;
  logic [11:0] out_bank, out_cnt;
  logic [3:0] out_lane_vld;

  always #2.5 clk = ~clk;

  vec_agen u_vec_agen (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_mode(cfg_mode),
    .cfg_width(cfg_width), .cfg_vlen(cfg_vlen), .cfg_base(cfg_base),
    .cfg_stride(cfg_stride), .idx_valid(idx_valid), .idx_ready(idx_ready),
    .idx_off(idx_off), .out_valid(out_valid), .out_ready(out_ready),
    .out_addr(out_addr), .out_bank(out_bank), .out_lane_vld(out_lane_vld),
    .out_cnt(out_cnt), .out_last(out_last), .done(done), .busy(busy)
  );

  int tests = 0, fails = 0;
  logic [31:0] ex_addr [0:63][0:3];
  int          ex_cnt  [0:63][0:3];
  logic [3:0]  ex_v    [0:63];
  logic [15:0] offs    [0:255];
  int ex_beats = 0, rx_beat = 0, rdy_pat = 0, cyc = 0, done_cnt = 0;
  logic pend_done = 1'b0, idx_seen = 1'b0, monitor_on = 1'b0, cur_idx = 1'b0;
  logic finished = 1'b0;

  task automatic chk(input bit ok, input string req, input string msg);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  // Monitor: chooses out_ready, then records the beat taken at the coming edge.
  always @(negedge clk) begin
    cyc++;
    if (pend_done) begin
      chk(done == 1'b1, "R7", $sformatf("done after last beat act=%0b exp=1", done));
      pend_done = 1'b0;
    end
    if (done) done_cnt++;
    if (idx_ready && !cur_idx) idx_seen = 1'b1;
    case (rdy_pat)
      0: out_ready = 1'b1;
      1: out_ready = cyc[0];
      default: out_ready = ($urandom % 3) != 0;
    endcase
    if (monitor_on && out_valid && out_ready) begin
      if (rx_beat >= ex_beats) begin
        chk(1'b0, "R3", $sformatf("extra beat act=%0d exp=%0d", rx_beat + 1, ex_beats));
      end else begin
        bit ok = (out_lane_vld == ex_v[rx_beat]) &&
                 (out_last == (rx_beat == ex_beats - 1));
        for (int j = 0; j < 4; j++) begin
          if (ex_v[rx_beat][j]) begin
            ok &= out_addr[j*32 +: 32] == ex_addr[rx_beat][j];
            ok &= out_bank[j*3 +: 3] == ex_addr[rx_beat][j][7:5];
            ok &= out_cnt[j*3 +: 3] == 3'(ex_cnt[rx_beat][j]);
          end
        end
        chk(ok, "R1 R2 R4 R5", $sformatf(
          "beat %0d act v=%b a0=%h a1=%h a2=%h a3=%h cnt=%h last=%0b exp v=%b a0=%h a1=%h a2=%h a3=%h c0=%0d",
          rx_beat, out_lane_vld, out_addr[31:0], out_addr[63:32], out_addr[95:64],
          out_addr[127:96], out_cnt, out_last, ex_v[rx_beat], ex_addr[rx_beat][0],
          ex_addr[rx_beat][1], ex_addr[rx_beat][2], ex_addr[rx_beat][3], ex_cnt[rx_beat][0]));
        if (rx_beat == ex_beats - 1) pend_done = 1'b1;
      end
      rx_beat++;
    end
  end

  task automatic build(input int mode, input int w, input int vl,
                       input logic [31:0] base, input int stride);
    int bytes = (w == 0) ? 2 : (w == 1) ? 4 : 8;
    int s = (mode == 0) ? 1 : stride;
    bit fast = (mode == 0) || (mode != 2 && s >= 1 && s <= 4);
    int lead = 0;
    logic [31:0] prev = '0;
    ex_beats = (vl + 3) / 4;
    for (int b = 0; b < 64; b++) begin
      ex_v[b] = '0;
      for (int j = 0; j < 4; j++) ex_cnt[b][j] = 0;
    end
    for (int e = 0; e < vl; e++) begin
      logic [31:0] a;
      int b = e / 4, l = e % 4;
      if (mode == 2) a = base + {16'h0, offs[e]};
      else           a = base + 32'(e * s * bytes);
      ex_addr[b][l] = a;
      if (l == 0 || !fast || (a >> 5) != (prev >> 5)) begin
        lead = l;
        ex_v[b][l] = 1'b1;
        ex_cnt[b][l] = 1;
      end else begin
        ex_cnt[b][lead]++;
      end
      prev = a;
    end
  endtask

  task automatic feed(input int beats);
    int p = 0;
    while (p < beats) begin
      @(negedge clk);
      idx_valid = 1'b1;
      idx_off = {offs[4*p+3], offs[4*p+2], offs[4*p+1], offs[4*p]};
      if (idx_ready) p++;
    end
    @(negedge clk);
    idx_valid = 1'b0;
  endtask

  task automatic run(input int mode, input int w, input int vl,
                     input logic [31:0] base, input int stride,
                     input int pat, input bit poke);
    int d0;
    while (busy) @(negedge clk);
    @(negedge clk);
    build(mode, w, vl, base, stride);
    rx_beat = 0; rdy_pat = pat; monitor_on = 1'b1;
    idx_seen = 1'b0; cur_idx = (mode == 2);
    d0 = done_cnt;
    cfg_mode = 2'(mode); cfg_width = 2'(w); cfg_vlen = 8'(vl);
    cfg_base = base; cfg_stride = 8'(stride);
    start = 1'b1;
    if (mode == 2 && vl > 0) fork feed(ex_beats); join_none
    @(negedge clk);
    start = 1'b0;
    if (vl == 0)
      chk(done == 1'b1 && !out_valid, "R8", $sformatf("zero length done=%0b valid=%0b exp 1/0", done, out_valid));
    if (poke) begin
      repeat (3) @(negedge clk);
      // R9: a second start with a different configuration while busy
      chk(busy == 1'b1, "R9", $sformatf("busy before poke act=%0b exp=1", busy));
      cfg_vlen = 8'd1; cfg_base = 32'hdead_0000; cfg_mode = 2'd1; cfg_stride = 8'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(done_cnt == d0 + 1 && rx_beat == ex_beats, "R7 R9",
        $sformatf("done pulses act=%0d exp=1, beats act=%0d exp=%0d",
                  done_cnt - d0, rx_beat, ex_beats));
    if (mode != 2) chk(!idx_seen, "R10", $sformatf("idx_ready act=%0b exp=0", idx_seen));
    monitor_on = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete act=hung exp=done");
    summary();
  end

  initial begin
    int strides[6] = '{1, 2, 3, 4, 5, 9};
    int lens[6] = '{1, 3, 4, 5, 8, 11};
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(!out_valid && !done && !busy && !idx_ready, "R11",
        $sformatf("reset v=%0b d=%0b b=%0b ir=%0b exp 0000", out_valid, done, busy, idx_ready));
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && !busy, "R11", $sformatf("idle after reset v=%0b b=%0b exp 00", out_valid, busy));

    for (int e = 0; e < 256; e++) offs[e] = 16'($urandom);

    // R1 R5 strided sweep over width, stride, length
    for (int w = 0; w < 3; w++)
      for (int si = 0; si < 6; si++)
        for (int li = 0; li < 6; li++)
          run(1, w, lens[li], 32'h0000_1000 + 32'(6 * li + 2 * w), strides[si],
              (w + si + li) % 3, 1'b0);

    // R1 R5 unit-stride, width code 3 and mode code 3
    for (int w = 0; w < 4; w++) begin
      run(0, w, 2, 32'h0002_0010, 0, 0, 1'b0);
      run(0, w, 7, 32'h0002_001a, 0, 1, 1'b0);
      run(0, w, 16, 32'h0002_0000, 0, 2, 1'b0);
      run(0, w, 33, 32'h0002_0006, 0, 2, 1'b0);
    end
    run(3, 1, 9, 32'h0000_0f00, 2, 2, 1'b0);
    run(1, 0, 10, 32'hffff_fff0, 3, 0, 1'b0);
    run(1, 1, 6, 32'h0000_0040, 0, 1, 1'b0);

    // R2 indexed with assorted lengths and stalls
    run(2, 0, 1, 32'h0003_0000, 0, 0, 1'b0);
    run(2, 1, 4, 32'h0003_0000, 0, 1, 1'b0);
    run(2, 2, 6, 32'hffff_ff00, 0, 2, 1'b0);
    run(2, 0, 13, 32'h0000_0100, 0, 2, 1'b0);
    run(2, 2, 29, 32'h0004_0000, 0, 1, 1'b0);

    // R8 zero length in each mode
    run(0, 0, 0, 32'h10, 0, 0, 1'b0);
    run(1, 1, 0, 32'h10, 3, 0, 1'b0);
    run(2, 2, 0, 32'h10, 0, 0, 1'b0);

    // R9 start while busy, under stalls
    run(1, 2, 32, 32'h0005_0000, 1, 1, 1'b1);
    run(2, 1, 24, 32'h0006_0000, 0, 2, 1'b1);

    summary();
  end
endmodule